// File: doc/BRIEF.md
# Serial Sample Loader for a Small Inference Engine

This block sits between a host microcontroller's SPI master and a fixed-size neural inference engine. The host uses it to deposit six 17-bit input samples into registers that the engine reads directly. After a complete set has been written, the block signals the engine to begin. The host then fetches the engine's 4-bit class result over the same link.

Every transaction is framed by chip select. It opens with a 24-bit header: an 8-bit opcode followed by a 16-bit register address. The header is followed by any number of 16-bit data frames, and the address steps by one after each frame. A 17-bit sample occupies two consecutive addresses. The even address holds the sample's top bit in its least significant position. The odd address holds the sample's lower sixteen bits.

The serial clock, chip select and data input are synchronized into the system clock domain. The serial clock must therefore run several times slower than the system clock. The link uses SPI mode 0 (clock idles low, data sampled on the rising edge) with the most significant bit first.

Top module: `spi_sample_loader`

## Requirements
- R1: A transaction header is the first 24 bits after chip select goes low, MSB first, sampled on SCLK rising edges: bits 23..16 are the opcode, bits 15..0 the start address; opcode 0x02 writes and 0x03 reads.
- R2: In a write, a complete frame at address 2k (k = 0..5) sets bit 16 of sample k to the frame's bit 0 and ignores frame bits 15..1; a frame at address 2k+1 sets bits 15..0 of sample k. Sample k appears on `samples_o[17k+16:17k]`.
- R3: The address used by each data frame is the header address plus the number of frames already completed in the transaction.
- R4: Write frames whose address is 12 or higher change no sample.
- R5: `start_o` is high for exactly one clock cycle when a write transaction whose header address is 0 completes the frame at address 11. Other writes, including one that reaches address 11 from a nonzero start, give no pulse.
- R6: In a read, the first frame after the header returns {12'b0, `result_i`} MSB first, with `result_i` captured at the first SCLK falling edge after the header and MISO changing only after falling edges. Later frames return zero.
- R7: Raising chip select ends the transaction at once. A partly shifted header or frame is discarded, frames already completed stay written, and the next transaction starts with a fresh header.
- R8: MISO is low while chip select is high, throughout write transactions, and during the header of any transaction.
- R9: An opcode other than 0x02 or 0x03 changes no sample and causes no start pulse.
- R10: After reset all samples are zero, `start_o` is low and MISO is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| spi_sclk | input | 1 | Serial clock from the host (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select framing a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| result_i | input | 4 | Class result from the inference engine |
| samples_o | output | 102 | Six packed 17-bit samples; sample k at bits 17k+16..17k |
| start_o | output | 1 | One-cycle request to start an inference |

## Verification
The hardest conditions to reach are the ones where chip select rises partway through something. These include an abort inside the header, an abort after a completed frame but inside the next one, and a write burst that reaches the last address without starting at address 0. The bench produces each of them with a bit-level transfer task that takes an arbitrary bit count, so it can stop at any bit before raising chip select. After each such event it runs a fresh transaction. That transaction shows that completed frames were kept and partial ones dropped, and that the header counter started again from zero. Start pulses are counted by a monitor over the whole run, so a pulse produced by the wrong transaction is still caught.

// File: rtl/spi_loader_pkg.sv
package spi_loader_pkg;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_READ  = 8'h03;

  typedef enum logic [1:0] {
    OPK_NONE  = 2'd0,
    OPK_WRITE = 2'd1,
    OPK_READ  = 2'd2
  } op_kind_e;

  function automatic op_kind_e decode_op(input logic [7:0] opc);
    if (opc == OPC_WRITE)     return OPK_WRITE;
    else if (opc == OPC_READ) return OPK_READ;
    else                      return OPK_NONE;
  endfunction
endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic mosi_s
);
  // bit order in each stage: {sclk, cs_n, mosi}
  localparam logic [2:0] IDLE = 3'b010;

  logic [2:0] stg_q [STAGES];
  logic       sclk_prev_q;
  logic       sclk_s;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= IDLE;
        else if (i == 0) stg_q[i] <= {sclk_i, cs_n_i, mosi_i};
        else stg_q[i] <= stg_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign sclk_s = stg_q[STAGES-1][2];
  assign cs_act = ~stg_q[STAGES-1][1];
  assign mosi_s = stg_q[STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end

  assign sclk_rise = cs_act &  sclk_s & ~sclk_prev_q;
  assign sclk_fall = cs_act & ~sclk_s &  sclk_prev_q;
endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_loader_pkg::*;
#(
  parameter int CMD_W    = 8,
  parameter int ADDR_W   = 16,
  parameter int FRAME_W  = 16,
  parameter int RESULT_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_rise,
  input  logic                sclk_fall,
  input  logic                cs_act,
  input  logic                mosi_s,
  input  logic [RESULT_W-1:0] result_i,
  output logic                miso_o,
  output logic                wr_en_o,
  output logic [ADDR_W-1:0]   wr_addr_o,
  output logic [FRAME_W-1:0]  wr_data_o,
  output logic                from_base_o
);
  localparam int HDR_W = CMD_W + ADDR_W;
  localparam int CNT_W = $clog2(HDR_W);

  logic [HDR_W-1:0]   sh_q, sh_d, sh_next;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               hdr_q, hdr_d;
  op_kind_e           op_q, op_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic               base_q, base_d;
  logic               load_q, load_d;
  logic [FRAME_W-1:0] tx_q, tx_d, rd_frame;
  logic               miso_q, miso_d;
  logic               wr_en_q, wr_en_d;
  logic [ADDR_W-1:0]  wr_addr_q, wr_addr_d;
  logic [FRAME_W-1:0] wr_data_q, wr_data_d;

  assign sh_next  = {sh_q[HDR_W-2:0], mosi_s};
  assign rd_frame = {{(FRAME_W-RESULT_W){1'b0}}, result_i};

  always_comb begin
    sh_d = sh_q;     cnt_d = cnt_q;   hdr_d = hdr_q;   op_d = op_q;
    addr_d = addr_q; base_d = base_q; load_d = load_q; tx_d = tx_q;
    miso_d = miso_q; wr_en_d = 1'b0;  wr_addr_d = wr_addr_q; wr_data_d = wr_data_q;
    if (!cs_act) begin
      cnt_d = '0; hdr_d = 1'b0; op_d = OPK_NONE; load_d = 1'b0;
      tx_d = '0;  miso_d = 1'b0;
    end else begin
      if (sclk_rise) begin
        sh_d = sh_next;
        if (!hdr_q) begin
          if (cnt_q == CNT_W'(HDR_W-1)) begin
            cnt_d  = '0;
            hdr_d  = 1'b1;
            addr_d = sh_next[ADDR_W-1:0];
            base_d = (sh_next[ADDR_W-1:0] == '0);
            op_d   = decode_op(sh_next[HDR_W-1 -: CMD_W]);
            load_d = (decode_op(sh_next[HDR_W-1 -: CMD_W]) == OPK_READ);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (cnt_q == CNT_W'(FRAME_W-1)) begin
          cnt_d     = '0;
          addr_d    = addr_q + 1'b1;
          wr_en_d   = (op_q == OPK_WRITE);
          wr_addr_d = addr_q;
          wr_data_d = sh_next[FRAME_W-1:0];
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (sclk_fall) begin
        if (load_q) begin
          miso_d = rd_frame[FRAME_W-1];
          tx_d   = rd_frame << 1;
          load_d = 1'b0;
        end else begin
          miso_d = tx_q[FRAME_W-1];
          tx_d   = tx_q << 1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; cnt_q <= '0; hdr_q <= 1'b0; op_q <= OPK_NONE;
      addr_q <= '0; base_q <= 1'b0; load_q <= 1'b0; tx_q <= '0;
      miso_q <= 1'b0; wr_en_q <= 1'b0; wr_addr_q <= '0; wr_data_q <= '0;
    end else begin
      sh_q <= sh_d; cnt_q <= cnt_d; hdr_q <= hdr_d; op_q <= op_d;
      addr_q <= addr_d; base_q <= base_d; load_q <= load_d; tx_q <= tx_d;
      miso_q <= miso_d; wr_en_q <= wr_en_d; wr_addr_q <= wr_addr_d; wr_data_q <= wr_data_d;
    end
  end

  assign miso_o      = miso_q;
  assign wr_en_o     = wr_en_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign from_base_o = base_q;

  // R7: an inactive select leaves the engine waiting for a new header
  p_bitcnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (cnt_q == '0 && !hdr_q));
  // R1: data frames are only committed once a header has been taken
  p_wr_after_hdr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> hdr_q);
  // R8: MISO idles low with select inactive
  p_miso_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !miso_q);
  // R8: non-read transactions never drive a one
  p_miso_nonread_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_q && op_q != OPK_READ) |-> !miso_q);
endmodule

// File: rtl/sample_regbank.sv
module sample_regbank #(
  parameter int N_SAMPLES = 6,
  parameter int SAMPLE_W  = 17,
  parameter int FRAME_W   = 16,
  parameter int ADDR_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [FRAME_W-1:0]            wr_data_i,
  input  logic                          from_base_i,
  output logic [N_SAMPLES*SAMPLE_W-1:0] samples_o,
  output logic                          start_o
);
  localparam int LOW_W   = SAMPLE_W - 1;
  localparam int N_ADDR  = 2 * N_SAMPLES;
  localparam int LAST_AD = N_ADDR - 1;

  generate
    for (genvar k = 0; k < N_SAMPLES; k++) begin : g_smp
      logic             hi_q, hi_d, hi_en;
      logic [LOW_W-1:0] lo_q, lo_d, lo_en;
      always_comb begin
        hi_en = wr_en_i && (wr_addr_i == ADDR_W'(2*k));
        lo_en = {LOW_W{wr_en_i && (wr_addr_i == ADDR_W'(2*k+1))}};
        hi_d  = wr_data_i[0];
        lo_d  = wr_data_i[LOW_W-1:0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          hi_q <= 1'b0;
          lo_q <= '0;
        end else begin
          if (hi_en)    hi_q <= hi_d;
          if (lo_en[0]) lo_q <= lo_d;
        end
      end
      assign samples_o[k*SAMPLE_W +: SAMPLE_W] = {hi_q, lo_q};
    end
  endgenerate

  logic start_q, start_d;
  always_comb start_d = wr_en_i && from_base_i && (wr_addr_i == ADDR_W'(LAST_AD));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end
  assign start_o = start_q;

  // R5: the start request lasts a single cycle
  p_start_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  // R5: a start request follows a write to the last sample address
  p_start_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(wr_en_i && wr_addr_i == ADDR_W'(LAST_AD)));
endmodule

// File: rtl/spi_sample_loader.sv
module spi_sample_loader #(
  parameter int N_SAMPLES   = 6,
  parameter int SAMPLE_W    = 17,
  parameter int RESULT_W    = 4,
  parameter int FRAME_W     = 16,
  parameter int ADDR_W      = 16,
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          spi_sclk,
  input  logic                          spi_cs_n,
  input  logic                          spi_mosi,
  output logic                          spi_miso,
  input  logic [RESULT_W-1:0]           result_i,
  output logic [N_SAMPLES*SAMPLE_W-1:0] samples_o,
  output logic                          start_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic sclk_rise, sclk_fall, cs_act, mosi_s;
  logic wr_en, from_base;
  logic [ADDR_W-1:0]  wr_addr;
  logic [FRAME_W-1:0] wr_data;

  spi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n),
    .sclk_i(spi_sclk), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s)
  );

  spi_frame_engine #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .RESULT_W(RESULT_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_int_n),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act), .mosi_s(mosi_s),
    .result_i(result_i), .miso_o(spi_miso),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .from_base_o(from_base)
  );

  sample_regbank #(
    .N_SAMPLES(N_SAMPLES), .SAMPLE_W(SAMPLE_W), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .from_base_i(from_base),
    .samples_o(samples_o), .start_o(start_o)
  );
endmodule

// File: tb/sim_spi_sample_loader.sv
module sim_spi_sample_loader;
  localparam int HALF = 8;

  logic clk, rst_n, sclk, cs_n, mosi, miso, start;
  logic [3:0]   result;
  logic [101:0] samples;

  int checks, fails, start_cycles, start_edges;
  logic start_prev;
  bit done;

  spi_sample_loader u0 (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .result_i(result), .samples_o(samples), .start_o(start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) start_prev <= 1'b0;
    else begin
      if (start) start_cycles++;
      if (start && !start_prev) start_edges++;
      start_prev <= start;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [16:0] smp(input int k);
    return samples[k*17 +: 17];
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input int n, input logic [23:0] val, output logic [23:0] rx);
    rx = '0;
    for (int i = n-1; i >= 0; i--) begin
      mosi = val[i];
      wait_clk(HALF);
      rx = {rx[22:0], miso};
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(4*HALF);
  endtask

  logic [16:0] ref_s [6];

  task automatic check_all(input string req);
    for (int k = 0; k < 6; k++)
      check(smp(k) == ref_s[k], req, $sformatf("sample %0d", k), 32'(smp(k)), 32'(ref_s[k]));
  endtask

  task automatic t_reset();
    for (int k = 0; k < 6; k++) ref_s[k] = '0;
    check_all("R10");
    check(start == 1'b0, "R10", "start after reset", 32'(start), 0);
    check(miso == 1'b0, "R10", "miso after reset", 32'(miso), 0);
  endtask

  task automatic t_full_write();
    logic [23:0] rx;
    logic miso_or;
    int e0;
    logic [16:0] v [6];
    v[0] = 17'h12345; v[1] = 17'h0ABCD; v[2] = 17'h1FFFF;
    v[3] = 17'h00001; v[4] = 17'h18000; v[5] = 17'h07FFF;
    e0 = start_edges;
    miso_or = 1'b0;
    sel();
    xfer(24, {8'h02, 16'h0000}, rx);
    miso_or |= |rx;
    for (int k = 0; k < 6; k++) begin
      // R2: upper bits of the even frame are junk and must be ignored
      xfer(16, {8'h00, (k == 1) ? 16'hFFFE : 16'h0000} | 24'(v[k][16]), rx);
      miso_or |= |rx;
      xfer(16, {8'h00, v[k][15:0]}, rx);
      miso_or |= |rx;
      ref_s[k] = v[k];
    end
    desel();
    check_all("R2");
    check(start_edges == e0 + 1, "R5", "start pulses after full write", 32'(start_edges), 32'(e0 + 1));
    check(start_cycles == start_edges, "R5", "start high cycles", 32'(start_cycles), 32'(start_edges));
    check(miso_or == 1'b0, "R8", "miso during write", 32'(miso_or), 0);
  endtask

  task automatic t_offset_write();
    logic [23:0] rx;
    int e0;
    e0 = start_edges;
    sel();
    xfer(24, {8'h02, 16'h0005}, rx);
    xfer(16, 24'h001111, rx);
    xfer(16, 24'h000000, rx);
    xfer(16, 24'h002222, rx);
    desel();
    ref_s[2] = 17'h11111;
    ref_s[3] = 17'h02222;
    check_all("R3");
    check(start_edges == e0, "R5", "no start for offset write", 32'(start_edges), 32'(e0));
  endtask

  task automatic t_range();
    logic [23:0] rx;
    int e0;
    e0 = start_edges;
    sel();
    xfer(24, {8'h02, 16'h000B}, rx);
    xfer(16, 24'h004444, rx);
    xfer(16, 24'h005555, rx);
    xfer(16, 24'h006666, rx);
    desel();
    ref_s[5] = {ref_s[5][16], 16'h4444};
    check_all("R4");
    check(start_edges == e0, "R5", "no start when reaching last from 11", 32'(start_edges), 32'(e0));
  endtask

  task automatic t_bad_op();
    logic [23:0] rx;
    int e0;
    e0 = start_edges;
    sel();
    xfer(24, {8'h05, 16'h0000}, rx);
    for (int i = 0; i < 12; i++) xfer(16, 24'h00FFFF, rx);
    desel();
    check_all("R9");
    check(start_edges == e0, "R9", "no start for unknown opcode", 32'(start_edges), 32'(e0));
  endtask

  task automatic t_read(input logic [3:0] r);
    logic [23:0] rx;
    result = r;
    sel();
    xfer(24, {8'h03, 16'h0000}, rx);
    check(rx == 24'h0, "R8", "miso during read header", 32'(rx), 0);
    xfer(16, 24'h0, rx);
    check(rx[15:0] == {12'h0, r}, "R6", "read frame", 32'(rx[15:0]), 32'(r));
    xfer(16, 24'h0, rx);
    check(rx[15:0] == 16'h0, "R6", "second read frame", 32'(rx[15:0]), 0);
    desel();
    check(miso == 1'b0, "R8", "miso after deselect", 32'(miso), 0);
  endtask

  task automatic t_abort();
    logic [23:0] rx;
    int e0;
    e0 = start_edges;
    sel();
    xfer(24, {8'h02, 16'h0000}, rx);
    xfer(16, 24'h000000, rx);
    xfer(8, 24'h0000FF, rx);
    desel();
    ref_s[0] = {1'b0, ref_s[0][15:0]};
    check_all("R7");
    // abort inside a header, then a clean write to address 1
    sel();
    xfer(10, 24'h3FF, rx);
    desel();
    sel();
    xfer(24, {8'h02, 16'h0001}, rx);
    xfer(16, 24'h0000AA, rx);
    desel();
    ref_s[0] = {ref_s[0][16], 16'h00AA};
    check(smp(0) == ref_s[0], "R7", "write after header abort", 32'(smp(0)), 32'(ref_s[0]));
    check(start_edges == e0, "R7", "no start after abort", 32'(start_edges), 32'(e0));
  endtask

  initial begin
    checks = 0; fails = 0; start_cycles = 0; start_edges = 0; done = 1'b0;
    sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; result = 4'h0; rst_n = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_full_write();
    t_offset_write();
    t_range();
    t_bad_op();
    t_read(4'hA);
    t_read(4'h5);
    t_abort();
    t_read(4'hF);
    t_full_write();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_clk(150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule